// File: doc/BRIEF.md
# Clock-Gated Moore State Machine

This block is a three-state Moore machine whose state register receives a clock edge only when the state is actually about to change. Each state has input codes that keep it where it is. When the present state and the 2-bit input code select one of these self-loops, activation logic withholds the enable from the clock gate, and the state flip-flops see no edge in that cycle. The outputs depend only on the state, so a withheld edge never alters them. A skipped edge saves the switching of the register and of everything its clock reaches.

The activation value is the comparison "computed next state differs from present state". It is taken from the same next-state function that feeds the register. A level-sensitive latch holds this value and is open only while the primary clock is low. The gated clock is the AND of the primary clock and the latched value, so it cannot pulse part-way through a high phase. The gated clock is also driven onto a port so that it can be observed. An active-low asynchronous reset forces the initial state whether or not the gate is open.

Top module: `fsmcg_top`

## Requirements
- R1: Driving `rst_ni` low forces state S0 without waiting for a clock edge. In S0, `out_o` reads 4'b0001.
- R2: On an enabled edge the next state follows this rule, with `sym_i` read as an unsigned 2-bit code. From S0, code 1 goes to S1 and code 2 goes to S2. From S1, code 2 goes to S2 and code 3 goes to S0. From S2, code 0 goes to S0 and code 1 goes to S1. Every other state/code pair is a self-loop.
- R3: `out_o` is one-hot on the state index: bit 0 is set in S0, bit 1 in S1 and bit 2 in S2, and all higher bits are zero. `out_o` changes only when the state changes.
- R4: In a cycle whose state/code pair is a self-loop, `gclk_o` stays low for the whole high phase of `clk_i`, and the state and outputs are held.
- R5: In a cycle whose pair leads to a different state, `gclk_o` is high during the high phase of `clk_i`. `gclk_o` is low whenever `clk_i` is low.
- R6: The enable is captured while `clk_i` is low. A change of `sym_i` during the high phase neither starts nor cuts short a `gclk_o` pulse in that phase.
- R7: Over a long input sequence, the output trace equals that of an ungated reference machine. The number of `gclk_o` rising edges equals the number of `clk_i` cycles minus the number of self-loop cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running primary clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_i | input | 2 | Input code that selects the transition |
| out_o | output | OUT_W (4) | Moore outputs, one-hot on the state |
| gclk_o | output | 1 | Gated clock of the state register, for observation |

## Verification
The assertions take `sym_i` to be a known 2-state value and `clk_i` to run freely. They also take reset to be applied and released only while `clk_i` is low, because the enable-versus-state properties relate samples one rising edge apart. The bench changes `sym_i` on falling edges and, to provoke R6, sometimes again shortly after a rising edge. It asserts and releases reset only within the low phase.

// File: rtl/fsmcg_pkg.sv
package fsmcg_pkg;

  localparam int SYM_W  = 2;
  localparam int ST_W   = 2;
  localparam int NUM_ST = 3;

  typedef enum logic [ST_W-1:0] {
    ST_A = 2'd0,
    ST_B = 2'd1,
    ST_C = 2'd2
  } fsm_st_e;

  // Next-state rule of the example graph; unlisted pairs are self-loops.
  function automatic fsm_st_e fsm_next(input fsm_st_e cur, input logic [SYM_W-1:0] sym);
    fsm_st_e nxt;
    nxt = cur;
    unique case (cur)
      ST_A: begin
        if (sym == 2'd1) nxt = ST_B;
        else if (sym == 2'd2) nxt = ST_C;
      end
      ST_B: begin
        if (sym == 2'd2) nxt = ST_C;
        else if (sym == 2'd3) nxt = ST_A;
      end
      ST_C: begin
        if (sym == 2'd0) nxt = ST_A;
        else if (sym == 2'd1) nxt = ST_B;
      end
      default: nxt = ST_A;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/fsmcg_logic.sv
module fsmcg_logic
  import fsmcg_pkg::*;
(
  input  fsm_st_e          st_q,
  input  logic [SYM_W-1:0] sym_i,
  output fsm_st_e          st_nxt,
  output logic             adv_raw
);

  always_comb begin
    st_nxt  = fsm_next(st_q, sym_i);
    adv_raw = (st_nxt != st_q);
  end

endmodule

// File: rtl/fsmcg_clkgate.sv
module fsmcg_clkgate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_lat_o,
  output logic gclk_o
);

  // Transparent while the clock is low: enable is frozen across the high phase.
  always_latch begin
    if (!clk_i) en_lat_o <= en_i;
  end

  assign gclk_o = clk_i & en_lat_o;

endmodule

// File: rtl/fsmcg_statereg.sv
module fsmcg_statereg
  import fsmcg_pkg::*;
(
  input  logic    gclk_i,
  input  logic    rst_ni,
  input  fsm_st_e st_d,
  output fsm_st_e st_q
);

  always_ff @(posedge gclk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_A;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/fsmcg_outdec.sv
module fsmcg_outdec
  import fsmcg_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  fsm_st_e          st_q,
  output logic [OUT_W-1:0] out_o
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    if (i < NUM_ST) begin : g_live
      assign out_o[i] = (st_q == fsm_st_e'(ST_W'(i)));
    end else begin : g_zero
      assign out_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/fsmcg_top.sv
module fsmcg_top
  import fsmcg_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] sym_i,
  output logic [OUT_W-1:0] out_o,
  output logic             gclk_o
);

  fsm_st_e st_q;
  fsm_st_e st_nxt;
  logic    adv_raw;
  logic    adv_lat;

  fsmcg_logic u_logic (
    .st_q    (st_q),
    .sym_i   (sym_i),
    .st_nxt  (st_nxt),
    .adv_raw (adv_raw)
  );

  fsmcg_clkgate u_gate (
    .clk_i    (clk_i),
    .en_i     (adv_raw),
    .en_lat_o (adv_lat),
    .gclk_o   (gclk_o)
  );

  fsmcg_statereg u_reg (
    .gclk_i (gclk_o),
    .rst_ni (rst_ni),
    .st_d   (st_nxt),
    .st_q   (st_q)
  );

  fsmcg_outdec #(.OUT_W(OUT_W)) u_dec (
    .st_q  (st_q),
    .out_o (out_o)
  );

endmodule

// File: rtl/fsmcg_chk.sv
module fsmcg_chk #(
  parameter int OUT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gclk_i,
  input logic             adv_raw,
  input logic             adv_lat,
  input logic [1:0]       st_q,
  input logic [OUT_W-1:0] out_o
);

  // R1: while reset is held, the machine sits in S0
  p_reset_s0_r1: assert property (@(posedge clk_i) !rst_ni |-> (out_o == OUT_W'(1)));

  // R2: an enabled cycle always lands in a different state
  p_move_changes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_raw |=> (st_q != $past(st_q)));

  // R2: only the three legal state codes appear
  p_state_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) st_q != 2'b11);

  // R3: exactly one output bit set
  p_out_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(out_o) == 1);

  // R4: a self-loop cycle leaves state and outputs untouched
  p_loop_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_raw |=> ($stable(st_q) && $stable(out_o)));

  // R5: the gated clock is low just before every primary rising edge
  p_gclk_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) !gclk_i);

  // R6: the latch has tracked the activation value through the low phase
  p_latch_tracks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) adv_lat == adv_raw);

endmodule

bind fsmcg_top fsmcg_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gclk_i  (gclk_o),
  .adv_raw (adv_raw),
  .adv_lat (adv_lat),
  .st_q    (st_q),
  .out_o   (out_o)
);

// File: tb/sim_fsmcg_top.sv
module sim_fsmcg_top;

  localparam int CLK_PERIOD = 10;
  localparam int OUT_W      = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b1;
  logic [1:0]       sym_i = 2'd0;
  logic [OUT_W-1:0] out_o;
  logic             gclk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  fsmcg_top #(.OUT_W(OUT_W)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sym_i  (sym_i),
    .out_o  (out_o),
    .gclk_o (gclk_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [OUT_W-1:0] out;
    logic             pulse;
    logic             late;
  } exp_t;

  exp_t q[$];
  int   ref_st = 0;
  int   exp_edges = 0;
  int   supp = 0;
  int   drives = 0;
  int   g_edges = 0;
  bit   cnt_en = 1'b0;

  always @(posedge gclk_o) if (cnt_en) g_edges++;

  // reference graph written as target lookup per state
  function automatic int rnext(input int s, input int x);
    int t;
    t = s;
    if (s == 0 && (x == 1 || x == 2)) t = x;
    if (s == 1 && x == 2) t = 2;
    if (s == 1 && x == 3) t = 0;
    if (s == 2 && x <= 1) t = x;
    return t;
  endfunction

  function automatic logic [OUT_W-1:0] onehot(input int s);
    return OUT_W'(1) << s;
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int x, input bit late, input int late_x);
    int nx;
    @(negedge clk);
    sym_i = x[1:0];
    nx = rnext(ref_st, x);
    q.push_back('{out: onehot(nx), pulse: (nx != ref_st), late: late});
    drives++;
    if (nx != ref_st) exp_edges++;
    else supp++;
    ref_st = nx;
    if (late) begin
      @(posedge clk);
      #1 sym_i = late_x[1:0];
    end
  endtask

  // monitor: compare during each high phase
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.pulse ? "R2/R3 out after move" : "R4 out held on self-loop", out_o, e.out);
        check(e.late ? "R6 gclk with late input change" :
              (e.pulse ? "R5 gclk pulse on move" : "R4 gclk quiet on self-loop"),
              OUT_W'(gclk_o), OUT_W'(e.pulse));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1 reset state", out_o, 4'b0001);
    check("R5 gclk low in reset low phase", OUT_W'(gclk_o), '0);
    @(negedge clk);
    rst_ni = 1'b1;
    ref_st = 0;
    cnt_en = 1'b1;

    // every state/code pair of the graph (R2, R4)
    drive(0, 0, 0); drive(3, 0, 0); drive(1, 0, 0);
    drive(0, 0, 0); drive(1, 0, 0); drive(2, 0, 0);
    drive(2, 0, 0); drive(3, 0, 0); drive(1, 0, 0);
    drive(3, 0, 0); drive(2, 0, 0); drive(0, 0, 0);
    // R6: self-loop code, then an advancing code during the high phase
    drive(0, 1, 1);
    drive(1, 0, 0);
    // R6: advancing code, then a looping code during the high phase
    drive(2, 1, 1);
    // R7: long random run with occasional late changes
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 3), ($urandom_range(0, 7) == 0), $urandom_range(0, 3));
    end
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    check("R7 queue drained", OUT_W'(q.size()), '0);
    n_chk++;
    if (g_edges != exp_edges) begin
      n_bad++;
      $display("FAIL R7 gated edges actual=%0d expected=%0d", g_edges, exp_edges);
    end
    n_chk++;
    if (drives - g_edges != supp) begin
      n_bad++;
      $display("FAIL R7 suppressed edges actual=%0d expected=%0d", drives - g_edges, supp);
    end

    // R1: asynchronous reset from S2 with no clock edge
    drive(2, 0, 0);
    repeat (2) @(negedge clk);
    check("R1 pre-reset state S2", out_o, 4'b0100);
    #1 rst_ni = 1'b0;
    #1 check("R1 async reset without edge", out_o, 4'b0001);
    @(negedge clk);
    rst_ni = 1'b1;
    ref_st = 0;
    drive(1, 0, 0);
    repeat (2) @(negedge clk);
    check("R2 move after reset release", out_o, 4'b0010);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule